// File: doc/BRIEF.md
# Clock Source Request Register with Power-of-Two Postscaler

This block holds a one-byte control word through which software asks for a new clock source and a new postscaler ratio. The source field carries a 3-bit code naming one of five oscillator choices. The divide field carries a 4-bit code N that selects a ratio of 2^N. The block validates each field of a write on its own and drops any field that holds a reserved code. A configuration lock input can freeze the whole word. The contents after reset are taken from a 3-bit reset-source configuration input, not from a fixed constant.

The same block drives a free-running postscaler from the divide field. The postscaler produces a one-cycle enable pulse once every 2^N input clocks. A new divide code is taken up only at the end of the period in progress, so a period is never cut short. The oscillator multiplexer, the PLL, the switchover handshake and the frequency trim lie outside this block; they consume the requested codes.

Top module: `clk_src_req_reg`

## Requirements
- R1: The read port always returns {1'b0, source[2:0], divide[3:0]}, with bit 7 at 0 whether or not the lock is active. Bit 7 of a write has no effect.
- R2: The valid source codes are 111 (external oscillator), 110 (fast internal), 101 (slow internal), 100 (secondary oscillator) and 010 (external with 4x PLL). An accepted write with one of these codes in bits 6:4 loads it into the source field on the next clock.
- R3: A write whose bits 6:4 hold 011, 001 or 000 leaves the source field unchanged. The divide field of that write is still judged on its own.
- R4: Divide codes 0000 to 1001 are valid and are loaded from bits 3:0 of an accepted write. Codes 1010 to 1111 leave the divide field unchanged, and the source field of that write is still judged on its own.
- R5: While the switch-enable configuration input is 0, writes change neither field.
- R6: While reset is asserted, the fields take these values from the reset-source configuration (config → source/divide): 000→110/0000, 010→010/0000, 100→100/0000, 101→101/0000, 110→110/0010, 111→111/0000.
- R7: The reserved reset-source configurations 001 and 011 give source 111 and divide 0000.
- R8: The postscaler enable is high for one cycle in every 2^N cycles, where N is the active divide code. After reset, the first pulse falls in the 2^N-th cycle.
- R9: A change of the divide field becomes the active code only when the current period ends. The period in progress keeps its old length.
- R10: If a write lands in the same cycle as a period end, the next period uses the divide value from before that write. The new value takes effect at the following period end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, also the postscaler's count clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_rst_src_i | input | 3 | Reset-source configuration that selects the reset contents |
| cfg_sw_en_i | input | 1 | Switch-enable configuration; 0 makes the register read-only |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data byte |
| rd_data_o | output | 8 | Read data: current register contents |
| src_req_o | output | 3 | Requested source code |
| div_req_o | output | 4 | Requested divide code |
| div_tick_o | output | 1 | Postscaler enable, one cycle per divided period |

## Verification
A bus write can land in the cycle where the postscaler completes a period, so a field update and a reload of the active ratio can coincide. The bench uses its reference model to find the cycle in which the period ends and places a divide write there. It also places writes in the middle of periods. Every pulse is judged against a model that reloads the ratio from the divide value held before that write. This shows whether the reload and the field update are ordered correctly against each other.

// File: rtl/csr_pkg.sv
// Package: shared widths, code checks and reset decode for the clock source
// request register. Assumes the byte layout {unused, source[2:0], divide[3:0]}.
package csr_pkg;

    localparam int SRC_W = 3;
    localparam int DIV_W = 4;
    localparam int REG_W = SRC_W + DIV_W + 1;

    localparam logic [SRC_W-1:0] SRC_EXT     = 3'b111;
    localparam logic [SRC_W-1:0] SRC_FAST    = 3'b110;
    localparam logic [SRC_W-1:0] SRC_SLOW    = 3'b101;
    localparam logic [SRC_W-1:0] SRC_SEC     = 3'b100;
    localparam logic [SRC_W-1:0] SRC_EXT_PLL = 3'b010;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } csr_fields_t;

    // True when the code names a real source (R2).
    function automatic logic src_code_ok(input logic [SRC_W-1:0] code);
        return (code == SRC_EXT) || (code == SRC_FAST) || (code == SRC_SLOW) ||
               (code == SRC_SEC) || (code == SRC_EXT_PLL);
    endfunction

    // True when the divide code lies in the supported range (R4).
    function automatic logic div_code_ok(input logic [DIV_W-1:0] code, input int max_code);
        return int'(code) <= max_code;
    endfunction

endpackage

// File: rtl/csr_reset_map.sv
// Module: csr_reset_map
// Decodes the reset-source configuration into the field values loaded at
// reset. Purely combinational; reserved configurations fall back to the
// external-oscillator setting so reset never yields a reserved code.
module csr_reset_map
    import csr_pkg::*;
(
    input  logic [SRC_W-1:0] cfg_i,
    output csr_fields_t      rst_val_o
);

    // Map each configuration to its reset contents.
    always_comb begin
        unique case (cfg_i)
            3'b110:  rst_val_o = '{src: SRC_FAST,    div: 4'b0010};
            3'b101:  rst_val_o = '{src: SRC_SLOW,    div: 4'b0000};
            3'b100:  rst_val_o = '{src: SRC_SEC,     div: 4'b0000};
            3'b010:  rst_val_o = '{src: SRC_EXT_PLL, div: 4'b0000};
            3'b000:  rst_val_o = '{src: SRC_FAST,    div: 4'b0000};
            default: rst_val_o = '{src: SRC_EXT,     div: 4'b0000};
        endcase
    end

endmodule

// File: rtl/csr_write_filter.sv
// Module: csr_write_filter
// Splits a bus write into per-field load enables. Each field is accepted
// only when the lock is open and its own code is valid. Assumes one-cycle
// write strobes; bit 7 of the data carries no meaning.
module csr_write_filter
    import csr_pkg::*;
#(
    parameter int DIV_MAX_CODE = 9
) (
    input  logic             wr_en_i,
    input  logic             sw_en_i,
    input  logic [REG_W-2:0] wr_field_i,
    output logic             src_we_o,
    output logic [SRC_W-1:0] src_wd_o,
    output logic             div_we_o,
    output logic [DIV_W-1:0] div_wd_o
);

    logic write_open;

    // A write counts only while the configuration lock allows changes.
    assign write_open = wr_en_i && sw_en_i;

    // Extract the fields and judge each one on its own.
    always_comb begin
        src_wd_o = wr_field_i[DIV_W +: SRC_W];
        div_wd_o = wr_field_i[0 +: DIV_W];
        src_we_o = write_open && src_code_ok(src_wd_o);
        div_we_o = write_open && div_code_ok(div_wd_o, DIV_MAX_CODE);
    end

endmodule

// File: rtl/csr_field_reg.sv
// Module: csr_field_reg
// One register field with a synchronous active-low reset to a value
// supplied at run time and a qualified load. Assumes the reset value is
// stable while reset is held.
module csr_field_reg #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] rst_val_i,
    input  logic         we_i,
    input  logic [W-1:0] wd_i,
    output logic [W-1:0] q_o
);

    // Hold the field; reset loads the decoded value, a qualified write the data.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q_o <= rst_val_i;
        end else if (we_i) begin
            q_o <= wd_i;
        end
    end

endmodule

// File: rtl/csr_postscaler.sv
// Module: csr_postscaler
// Free-running power-of-two divider. It emits a one-cycle enable every
// 2^N clocks and takes up a new N only when a period completes. Assumes
// the requested code never exceeds DIV_MAX_CODE.
module csr_postscaler
    import csr_pkg::*;
#(
    parameter int DIV_MAX_CODE = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] rst_div_i,
    input  logic [DIV_W-1:0] div_req_i,
    output logic             tick_o
);

    localparam int CNT_W = (DIV_MAX_CODE > 0) ? DIV_MAX_CODE : 1;

    logic [DIV_W-1:0] act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic             period_end;

    // Work out the last count value of the active period.
    always_comb begin
        span       = {{CNT_W{1'b0}}, 1'b1} << act_q;
        span_m1    = span - {{CNT_W{1'b0}}, 1'b1};
        period_end = ({1'b0, cnt_q} == span_m1);
    end

    // Advance the count; wrap at the period end and reload the active ratio.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            act_q <= rst_div_i;
        end else if (period_end) begin
            cnt_q <= '0;
            act_q <= div_req_i;
        end else begin
            cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    assign tick_o = period_end;

endmodule

// File: rtl/clk_src_req_reg.sv
// Module: clk_src_req_reg (top)
// Clock source request register with its postscaler. Reset contents come
// from the reset-source configuration; writes are filtered per field and
// blocked by the lock; the divide field drives the power-of-two divider.
// Assumes all inputs are synchronous to clk_i.
module clk_src_req_reg
    import csr_pkg::*;
#(
    parameter int DIV_MAX_CODE = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_W-1:0] cfg_rst_src_i,
    input  logic             cfg_sw_en_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [SRC_W-1:0] src_req_o,
    output logic [DIV_W-1:0] div_req_o,
    output logic             div_tick_o
);

    csr_fields_t      rst_val;
    logic             src_we;
    logic [SRC_W-1:0] src_wd;
    logic             div_we;
    logic [DIV_W-1:0] div_wd;
    logic             unused_wr_top;

    // Bit 7 of the write byte carries nothing.
    assign unused_wr_top = wr_data_i[REG_W-1];

    csr_reset_map u_rst_map (
        .cfg_i     (cfg_rst_src_i),
        .rst_val_o (rst_val)
    );

    csr_write_filter #(
        .DIV_MAX_CODE (DIV_MAX_CODE)
    ) u_wr_filt (
        .wr_en_i    (wr_en_i),
        .sw_en_i    (cfg_sw_en_i),
        .wr_field_i (wr_data_i[REG_W-2:0]),
        .src_we_o   (src_we),
        .src_wd_o   (src_wd),
        .div_we_o   (div_we),
        .div_wd_o   (div_wd)
    );

    csr_field_reg #(
        .W (SRC_W)
    ) u_src_fld (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rst_val_i (rst_val.src),
        .we_i      (src_we),
        .wd_i      (src_wd),
        .q_o       (src_req_o)
    );

    csr_field_reg #(
        .W (DIV_W)
    ) u_div_fld (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rst_val_i (rst_val.div),
        .we_i      (div_we),
        .wd_i      (div_wd),
        .q_o       (div_req_o)
    );

    csr_postscaler #(
        .DIV_MAX_CODE (DIV_MAX_CODE)
    ) u_post (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rst_div_i (rst_val.div),
        .div_req_i (div_req_o),
        .tick_o    (div_tick_o)
    );

    // Present the fields on the read port with the top bit cleared.
    assign rd_data_o = {1'b0, src_req_o, div_req_o};

endmodule

// File: rtl/clk_src_req_reg_chk.sv
// Module: clk_src_req_reg_chk
// Property checker attached to the top by bind. It watches the ports only
// and measures pulse spacing with its own counter.
module clk_src_req_reg_chk
    import csr_pkg::*;
#(
    parameter int DIV_MAX_CODE = 9
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cfg_sw_en_i,
    input logic             wr_en_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] rd_data_o,
    input logic [SRC_W-1:0] src_req_o,
    input logic [DIV_W-1:0] div_req_o,
    input logic             div_tick_o
);

    localparam int GAP_W   = DIV_MAX_CODE + 2;
    localparam int GAP_MAX = 1 << DIV_MAX_CODE;

    logic [GAP_W-1:0] gap_q;

    // Count cycles since the last pulse (or since reset), saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || div_tick_o) begin
            gap_q <= {{(GAP_W-1){1'b0}}, 1'b1};
        end else if (gap_q != {GAP_W{1'b1}}) begin
            gap_q <= gap_q + {{(GAP_W-1){1'b0}}, 1'b1};
        end
    end

    AST_TOP_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[REG_W-1] == 1'b0); // R1

    AST_SRC_NEVER_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_code_ok(src_req_o)); // R2

    AST_RSVD_SRC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !src_code_ok(wr_data_i[DIV_W +: SRC_W])) |=> $stable(src_req_o)); // R3

    AST_DIV_NEVER_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(div_req_o) <= DIV_MAX_CODE); // R4

    AST_LOCK_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_sw_en_i |=> ($stable(src_req_o) && $stable(div_req_o))); // R5

    AST_TICK_POW2_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_tick_o |-> ($countones(gap_q) == 1)); // R8

    AST_GAP_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(gap_q) <= GAP_MAX); // R8

endmodule

bind clk_src_req_reg clk_src_req_reg_chk #(
    .DIV_MAX_CODE (DIV_MAX_CODE)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_sw_en_i (cfg_sw_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .src_req_o   (src_req_o),
    .div_req_o   (div_req_o),
    .div_tick_o  (div_tick_o)
);

// File: tb/clk_src_req_reg_bench.sv
// Bench: a behavioural reference model stepped on every clock and compared
// with all outputs half a cycle later.
module clk_src_req_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg;
    logic       sw_en;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] src_req;
    logic [3:0] div_req;
    logic       tick;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string fld_tag  = "R6";
    string tick_tag = "R8";

    int m_src, m_div, m_act, m_cnt;

    always #10 clk = ~clk;

    clk_src_req_reg u_clk_src_req_reg (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .cfg_rst_src_i (cfg),
        .cfg_sw_en_i   (sw_en),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_data_o     (rd_data),
        .src_req_o     (src_req),
        .div_req_o     (div_req),
        .div_tick_o    (tick)
    );

    function automatic bit src_ok(int s);
        return s == 7 || s == 6 || s == 5 || s == 4 || s == 2;
    endfunction

    function automatic int rst_src(int c);
        case (c)
            6: return 6; 5: return 5; 4: return 4; 2: return 2; 0: return 6;
            default: return 7;
        endcase
    endfunction

    function automatic int rst_div(int c);
        return (c == 6) ? 2 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_src = rst_src(int'(cfg));
            m_div = rst_div(int'(cfg));
            m_act = m_div;
            m_cnt = 0;
        end else begin
            if (m_cnt == (1 << m_act) - 1) begin
                m_cnt = 0;
                m_act = m_div;
            end else begin
                m_cnt++;
            end
            if (wr_en && sw_en) begin
                if (src_ok(int'(wr_data[6:4]))) m_src = int'(wr_data[6:4]);
                if (int'(wr_data[3:0]) <= 9)    m_div = int'(wr_data[3:0]);
            end
        end
        @(negedge clk);
        chk("R1", "read", int'(rd_data), (m_src << 4) | m_div);
        chk(fld_tag, "source", int'(src_req), m_src);
        chk(fld_tag, "divide", int'(div_req), m_div);
        chk(tick_tag, "tick", int'(tick), int'(m_cnt == (1 << m_act) - 1));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset(logic [2:0] c);
        cfg = c;
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; cfg = 3'd7; sw_en = 1'b1; wr_en = 1'b0; wr_data = 8'h00;
        @(negedge clk);
        // R6 / R7: reset contents for every configuration value.
        for (int c = 0; c < 8; c++) begin
            fld_tag = (c == 1 || c == 3) ? "R7" : "R6";
            do_reset(3'(c));
            run(3);
        end
        do_reset(3'd7);
        // R2: each valid source code is loaded.
        fld_tag = "R2";
        wr(8'h61); wr(8'h51); wr(8'h41); wr(8'h21); wr(8'h71);
        // R3: reserved source codes keep the source; divide still applies.
        fld_tag = "R3";
        wr(8'h32); wr(8'h13); wr(8'h04);
        // R4: reserved divide codes keep the divide; source still applies.
        fld_tag = "R4";
        wr(8'h5A); wr(8'h6F); wr(8'h3C); wr(8'h49); wr(8'h40);
        // R1: bit 7 of a write has no effect and reads back as 0.
        fld_tag = "R1";
        wr(8'hF2); wr(8'hE0);
        // R5: lock blocks every write; reads still return the fields.
        fld_tag = "R5";
        sw_en = 1'b0;
        wr(8'h23); wr(8'h45); run(3); wr(8'h71);
        sw_en = 1'b1;
        // R8: pulse spacing at several ratios, reaching the largest.
        fld_tag = "R8"; tick_tag = "R8";
        wr(8'h70); run(10);
        wr(8'h73); run(40);
        wr(8'h79); run(1100);
        wr(8'h71); run(20);
        // R9: mid-period change waits for the period end.
        tick_tag = "R9"; fld_tag = "R9";
        wr(8'h74); run(20);
        while (m_cnt != 5) step();
        wr(8'h71); run(40);
        wr(8'h75); run(70);
        // R10: write landing on the period-end cycle.
        tick_tag = "R10"; fld_tag = "R10";
        for (int k = 0; k < 3; k++) begin
            while (m_cnt != (1 << m_act) - 1) step();
            wr((k == 1) ? 8'h70 : 8'h73);
            run(40);
        end
        while (m_cnt != (1 << m_act) - 1) step();
        wr(8'h72); run(30);
        // R6: reset after writes restores configured contents.
        fld_tag = "R6"; tick_tag = "R8";
        do_reset(3'd6);
        run(12);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule